// File: doc/BRIEF.md
# Wake-up Pin Edge Detector Controller

This block watches six asynchronous wake-up inputs from the pads. Each input is brought into the clock domain through a two-stage synchroniser. A rising or falling edge, chosen per pin, sets a sticky flag for that pin. A single interrupt line is high whenever at least one pin has both its flag and its enable bit set. Power-management firmware uses the interrupt to find out which pin caused a wake-up and then acknowledges it.

Software reaches the block through a small word-wide register port with three registers. The control register at offset 0x0 has three parts. Its low bits are acknowledge strobes. The per-pin edge select sits at bits 8+n. A 2-bit pull code per pin sits at bits 16+2n and 17+2n. The pull codes are not used inside the block; they are driven out to the pad logic. The flag register at offset 0x4 is read-only. The enable register at offset 0x8 gates each pin into the interrupt. A pin's flag is recorded even while that pin is disabled, so firmware can see which pins fired before it enables them.

Top module: `wkup_edge_ctrl`

## Requirements
- R1: After reset, all three registers read zero, the pull outputs are zero and the interrupt is low.
- R2: An edge on a pin appears at the flag and interrupt on the third rising clock edge after the pin changes. It does not appear earlier.
- R3: Control bit 8+n chooses the active edge for pin n: 1 selects falling and 0 selects rising. An edge of the other direction leaves the flag unchanged.
- R4: A flag is set on its active edge whether or not the pin is enabled. The interrupt is high exactly when some pin has both its flag and its enable bit (offset 0x8, bit n) set.
- R5: Writing 1 to control bit n (n in 0..5) clears flag n, and writing 0 there leaves the flag unchanged. These bits store nothing and always read back as 0.
- R6: If an active edge and a clear of the same pin land in the same cycle, the flag ends up set.
- R7: Changing a pin's edge select while the pin level is steady never sets a flag.
- R8: Pin n's pull code sits in control bits 16+2n and 17+2n and is driven on the pull outputs (0 none, 1 pull-up, 2 pull-down). A write of the reserved code 3 leaves that pin's field unchanged.
- R9: The flag register at offset 0x4 returns the flags in bits 5:0 and zeros above. Writes to it have no effect.
- R10: Read data and its valid strobe appear one cycle after the read request, and the strobe lasts one cycle. Offsets other than 0x0, 0x4 and 0x8 read as zero, and writes to them are ignored. Unused control bits read as zero.
- R11: A pin that is already high when reset is released does not produce a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wkup_pin_i | input | 6 | Asynchronous wake-up inputs |
| bus_valid_i | input | 1 | Register access request |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the request |
| bus_rvalid_o | output | 1 | Read data valid strobe |
| irq_o | output | 1 | Combined wake-up interrupt |
| pull_cfg_o | output | 12 | Pull codes, 2 bits per pin, pin n at bits 2n+1:2n |

## Verification
The bench puts an acknowledge write in the exact cycle in which a new edge sets the same flag. A design that gave the clear priority would lose that wake-up event. It flips edge selects while the pins are steady. A detector that compares the pin against the selected polarity, instead of against its own previous sample, would raise false flags there. It holds a pin high through reset and checks the synchroniser latency cycle by cycle, which catches an edge detector that wakes up against stale state or misses a stage. It writes the reserved pull code and uses unmapped offsets, to catch a register bank that stores illegal codes or aliases addresses.

// File: rtl/wkup_pkg.sv
// Shared constants and types for the wake-up edge controller.
// Assumes at most eight pins, so the pull fields fit in bits 31:16.
package wkup_pkg;
    localparam int unsigned WK_PINS     = 6;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned ADDR_W      = 4;
    localparam int unsigned SYNC_DEPTH  = 2;
    localparam int unsigned EDGE_LSB    = 8;
    localparam int unsigned PULL_LSB    = 16;
    localparam int unsigned PULL_W      = 2;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_FLAG = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_EN   = 4'h8;

    localparam logic [PULL_W-1:0] PULL_NONE = 2'd0;
    localparam logic [PULL_W-1:0] PULL_RSVD = 2'd3;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_FLAG = 2'd1,
        SEL_EN   = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/wkup_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes every bit is an independent, slowly changing level.
module wkup_sync #(
    parameter int unsigned WIDTH  = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First capture of the raw pad levels.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= async_i;
            end
        end else begin : g_next
            // Each later stage re-registers the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/wkup_edge_flag.sv
// Per-pin edge detection and sticky flags.
// An edge is found by comparing the synchronised level with the level
// one cycle earlier, so a polarity change alone can never create one.
// Detection stays off until the synchroniser and the history register
// hold real pad samples (ARM_CYCLES edges after reset).
module wkup_edge_flag #(
    parameter int unsigned WIDTH      = 6,
    parameter int unsigned ARM_CYCLES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_i,
    input  logic [WIDTH-1:0] fall_sel_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] evt_o,
    output logic [WIDTH-1:0] flag_o
);
    localparam int unsigned CNT_W = $clog2(ARM_CYCLES + 1);
    localparam logic [CNT_W-1:0] ARM_LAST = CNT_W'(ARM_CYCLES);

    logic [CNT_W-1:0] arm_cnt_q;
    logic             armed;
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] flag_q;

    assign armed = (arm_cnt_q == ARM_LAST);

    // Count the cycles after reset until the edge history is valid.
    always_ff @(posedge clk) begin
        if (!rst_n)      arm_cnt_q <= '0;
        else if (!armed) arm_cnt_q <= arm_cnt_q + 1'b1;
    end

    // Keep the previous synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_i;
    end

    for (genvar n = 0; n < WIDTH; n++) begin : g_pin
        logic rise;
        logic fall;
        assign rise     = sync_i[n] & ~prev_q[n];
        assign fall     = ~sync_i[n] & prev_q[n];
        assign evt_o[n] = armed & (fall_sel_i[n] ? fall : rise);

        // Sticky flag: a new event has priority over an acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_q[n] <= 1'b0;
            else if (evt_o[n]) flag_q[n] <= 1'b1;
            else if (clr_i[n]) flag_q[n] <= 1'b0;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/wkup_regs.sv
// Register bank: control (acknowledge strobes, edge select, pull codes),
// read-only flags and enables. Reads return data one cycle after the
// request. Unmapped offsets read zero and ignore writes.
module wkup_regs
    import wkup_pkg::*;
#(
    parameter int unsigned WIDTH = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_i,
    input  logic                write_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [WIDTH-1:0]    flag_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                rvalid_o,
    output logic [WIDTH-1:0]    fall_sel_o,
    output logic [WIDTH-1:0]    en_o,
    output logic [WIDTH-1:0]    clr_o,
    output logic [2*WIDTH-1:0]  pull_o
);
    reg_sel_e          sel;
    logic              wr_ctrl;
    logic              wr_en;
    logic              rd_req;
    logic [WIDTH-1:0]  fall_sel_q;
    logic [WIDTH-1:0]  en_q;
    logic [PULL_W-1:0] pull_q [WIDTH];
    logic [DATA_W-1:0] ctrl_view;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wdata;

    assign unused_wdata = ^wdata_i;

    // Decode the offset into one of the three registers.
    always_comb begin
        unique case (addr_i)
            OFS_CTRL: sel = SEL_CTRL;
            OFS_FLAG: sel = SEL_FLAG;
            OFS_EN:   sel = SEL_EN;
            default:  sel = SEL_NONE;
        endcase
    end

    assign wr_ctrl = valid_i & write_i & (sel == SEL_CTRL);
    assign wr_en   = valid_i & write_i & (sel == SEL_EN);
    assign rd_req  = valid_i & ~write_i;
    assign clr_o   = wr_ctrl ? wdata_i[WIDTH-1:0] : '0;

    // Store the edge selects on control writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       fall_sel_q <= '0;
        else if (wr_ctrl) fall_sel_q <= wdata_i[EDGE_LSB +: WIDTH];
    end

    // Store the enable mask on enable-register writes.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wdata_i[WIDTH-1:0];
    end

    for (genvar n = 0; n < WIDTH; n++) begin : g_pull
        // Accept a pull code unless it is the reserved value.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pull_q[n] <= PULL_NONE;
            else if (wr_ctrl && (wdata_i[PULL_LSB + PULL_W*n +: PULL_W] != PULL_RSVD))
                pull_q[n] <= wdata_i[PULL_LSB + PULL_W*n +: PULL_W];
        end
        assign pull_o[PULL_W*n +: PULL_W] = pull_q[n];
    end

    // Assemble the readable view of the control register.
    always_comb begin
        ctrl_view = '0;
        ctrl_view[EDGE_LSB +: WIDTH] = fall_sel_q;
        for (int n = 0; n < WIDTH; n++) begin
            ctrl_view[PULL_LSB + PULL_W*n +: PULL_W] = pull_q[n];
        end
    end

    // Select the read data for the addressed register.
    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_CTRL: rd_mux = ctrl_view;
            SEL_FLAG: rd_mux[WIDTH-1:0] = flag_i;
            SEL_EN:   rd_mux[WIDTH-1:0] = en_q;
            default:  rd_mux = '0;
        endcase
    end

    // Register the read response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_o <= 1'b0;
            rdata_o  <= '0;
        end else begin
            rvalid_o <= rd_req;
            rdata_o  <= rd_req ? rd_mux : '0;
        end
    end

    assign fall_sel_o = fall_sel_q;
    assign en_o       = en_q;
endmodule

// File: rtl/wkup_edge_ctrl.sv
// Top of the wake-up edge controller: synchroniser, edge/flag stage and
// register bank, plus the combined interrupt. Pins are assumed to be
// asynchronous levels that stay steady for several clock cycles.
module wkup_edge_ctrl
    import wkup_pkg::*;
#(
    parameter int unsigned NUM_PINS    = WK_PINS,
    parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PINS-1:0]      wkup_pin_i,
    input  logic                     bus_valid_i,
    input  logic                     bus_write_i,
    input  logic [ADDR_W-1:0]        bus_addr_i,
    input  logic [DATA_W-1:0]        bus_wdata_i,
    output logic [DATA_W-1:0]        bus_rdata_o,
    output logic                     bus_rvalid_o,
    output logic                     irq_o,
    output logic [PULL_W*NUM_PINS-1:0] pull_cfg_o
);
    localparam int unsigned ARM_CYCLES = SYNC_STAGES + 1;

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] fall_sel;
    logic [NUM_PINS-1:0] enable_q;
    logic [NUM_PINS-1:0] clr_mask;
    logic [NUM_PINS-1:0] edge_evt;
    logic [NUM_PINS-1:0] flag_q;

    wkup_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (wkup_pin_i),
        .sync_o  (pin_sync)
    );

    wkup_edge_flag #(.WIDTH(NUM_PINS), .ARM_CYCLES(ARM_CYCLES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (pin_sync),
        .fall_sel_i (fall_sel),
        .clr_i      (clr_mask),
        .evt_o      (edge_evt),
        .flag_o     (flag_q)
    );

    wkup_regs #(.WIDTH(NUM_PINS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (bus_valid_i),
        .write_i    (bus_write_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .flag_i     (flag_q),
        .rdata_o    (bus_rdata_o),
        .rvalid_o   (bus_rvalid_o),
        .fall_sel_o (fall_sel),
        .en_o       (enable_q),
        .clr_o      (clr_mask),
        .pull_o     (pull_cfg_o)
    );

    // Interrupt whenever any enabled pin holds a flag.
    assign irq_o = |(flag_q & enable_q);
endmodule

// File: rtl/wkup_edge_ctrl_chk.sv
// Property checker for wkup_edge_ctrl, attached by bind below.
module wkup_edge_ctrl_chk
    import wkup_pkg::*;
#(
    parameter int unsigned NUM_PINS = WK_PINS
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_valid_i,
    input logic                       bus_write_i,
    input logic [ADDR_W-1:0]          bus_addr_i,
    input logic [DATA_W-1:0]          bus_rdata_o,
    input logic                       bus_rvalid_o,
    input logic                       irq_o,
    input logic [PULL_W*NUM_PINS-1:0] pull_cfg_o,
    input logic [NUM_PINS-1:0]        edge_evt,
    input logic [NUM_PINS-1:0]        flag_q,
    input logic [NUM_PINS-1:0]        enable_q,
    input logic [NUM_PINS-1:0]        clr_mask
);
    logic unmapped;
    assign unmapped = (bus_addr_i != OFS_CTRL) && (bus_addr_i != OFS_FLAG) &&
                      (bus_addr_i != OFS_EN);

    // R1: first cycle out of reset is quiet.
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!irq_o && flag_q == '0 && enable_q == '0));

    // R10: a read request yields exactly one valid strobe next cycle.
    a_r10_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && !bus_write_i) |=> bus_rvalid_o);
    a_r10_no_stray_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid_i && !bus_write_i) |=> !bus_rvalid_o);
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && !bus_write_i && unmapped) |=> (bus_rdata_o == '0));

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        // R6: an edge always leaves the flag set, even against a clear.
        a_r6_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
            edge_evt[n] |=> flag_q[n]);
        // R5: a clear without a concurrent edge drops the flag.
        a_r5_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_mask[n] && !edge_evt[n]) |=> !flag_q[n]);
        // R7: a flag only rises because of a detected edge.
        a_r7_flag_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag_q[n] && !edge_evt[n]) |=> !flag_q[n]);
        // R8: the reserved pull code never reaches the pads.
        a_r8_no_reserved_pull: assert property (@(posedge clk) disable iff (!rst_n)
            pull_cfg_o[PULL_W*n +: PULL_W] != PULL_RSVD);
    end
endmodule

bind wkup_edge_ctrl wkup_edge_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid_i  (bus_valid_i),
    .bus_write_i  (bus_write_i),
    .bus_addr_i   (bus_addr_i),
    .bus_rdata_o  (bus_rdata_o),
    .bus_rvalid_o (bus_rvalid_o),
    .irq_o        (irq_o),
    .pull_cfg_o   (pull_cfg_o),
    .edge_evt     (edge_evt),
    .flag_q       (flag_q),
    .enable_q     (enable_q),
    .clr_mask     (clr_mask)
);

// File: tb/wkup_edge_ctrl_test.sv
// Bench for wkup_edge_ctrl: directed corner cases followed by random
// traffic, compared against a bench-side model of the registers.
module wkup_edge_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  pins;
    logic        bus_valid;
    logic        bus_write;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        irq;
    logic [11:0] pull_cfg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [5:0] m_pol, m_en, m_flag, m_pin;
    logic [1:0] m_pull [6];

    always #10 clk = ~clk;

    wkup_edge_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wkup_pin_i   (pins),
        .bus_valid_i  (bus_valid),
        .bus_write_i  (bus_write),
        .bus_addr_i   (bus_addr),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .bus_rvalid_o (bus_rvalid),
        .irq_o        (irq),
        .pull_cfg_o   (pull_cfg)
    );

    function automatic logic [31:0] exp_ctrl();
        logic [31:0] v = '0;
        v[13:8] = m_pol;
        for (int n = 0; n < 6; n++) v[16 + 2*n +: 2] = m_pull[n];
        return v;
    endfunction

    function automatic logic [11:0] exp_pull();
        logic [11:0] v;
        for (int n = 0; n < 6; n++) v[2*n +: 2] = m_pull[n];
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [3:0] a, logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(logic [3:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic model_ctrl(logic [31:0] d);
        m_flag &= ~d[5:0];
        m_pol   = d[13:8];
        for (int n = 0; n < 6; n++)
            if (d[16 + 2*n +: 2] != 2'd3) m_pull[n] = d[16 + 2*n +: 2];
    endtask

    task automatic ctrl_wr(logic [31:0] d);
        bus_wr(4'h0, d);
        model_ctrl(d);
    endtask

    task automatic en_wr(logic [5:0] e);
        bus_wr(4'h8, {26'd0, e});
        m_en = e;
    endtask

    // Drive new pin levels, let them settle, and update the model flags.
    task automatic pins_set(logic [5:0] nv);
        for (int n = 0; n < 6; n++) begin
            if (nv[n] && !m_pin[n] && !m_pol[n]) m_flag[n] = 1'b1;
            if (!nv[n] && m_pin[n] && m_pol[n])  m_flag[n] = 1'b1;
        end
        m_pin = nv;
        pins  = nv;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_all(string tag);
        logic [31:0] d;
        bus_rd(4'h0, d); check({tag, " ctrl"}, d, exp_ctrl());
        bus_rd(4'h4, d); check({tag, " flags"}, d, {26'd0, m_flag});
        bus_rd(4'h8, d); check({tag, " enable"}, d, {26'd0, m_en});
        check({tag, " pull"}, {20'd0, pull_cfg}, {20'd0, exp_pull()});
        check({tag, " irq"}, {31'd0, irq}, {31'd0, |(m_flag & m_en)});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic [31:0] seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
        pins = 6'b000100;
        rst_n = 1'b0;
        m_pol = '0; m_en = '0; m_flag = '0; m_pin = 6'b000100;
        for (int n = 0; n < 6; n++) m_pull[n] = 2'd0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // R1 and R11: quiet reset state, pin 2 high through reset is not flagged.
        check_all("R1 reset");
        bus_rd(4'h4, d); check("R11 no flag from reset level", d, 32'd0);

        // R2: latency of exactly three rising edges, seen on the interrupt.
        en_wr(6'b000001);
        pins[0] = 1'b1; m_pin[0] = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 not yet after two edges", {31'd0, irq}, 32'd0);
        @(negedge clk);
        check("R2 set after third edge", {31'd0, irq}, 32'd1);
        m_flag[0] = 1'b1;

        // R5: clear via control low bits; those bits read back zero.
        ctrl_wr(32'h0000_0001);
        check("R5 irq drops after clear", {31'd0, irq}, 32'd0);
        bus_rd(4'h0, d); check("R5 strobe bits read zero", {26'd0, d[5:0]}, 32'd0);

        // R3: falling select ignores rising edges and catches falling ones.
        ctrl_wr(32'h0000_0200);
        pins_set(m_pin | 6'b000010);
        bus_rd(4'h4, d); check("R3 rising ignored when falling selected", {31'd0, d[1]}, 32'd0);
        pins_set(m_pin & ~6'b000010);
        bus_rd(4'h4, d); check("R3 falling caught", {31'd0, d[1]}, 32'd1);

        // R4: flag without enable leaves irq low; enabling raises it.
        check("R4 disabled flag gives no irq", {31'd0, irq}, 32'd0);
        en_wr(6'b000011);
        check("R4 enable exposes flag", {31'd0, irq}, 32'd1);
        ctrl_wr(32'h0000_003F);
        en_wr(6'b000000);

        // R6: edge and clear of pin 3 in the same cycle.
        pins_set(m_pin | 6'b001000);
        pins_set(m_pin & ~6'b001000);
        pins[3] = 1'b1; m_pin[3] = 1'b1;
        repeat (2) @(negedge clk);
        bus_wr(4'h0, 32'h0000_0008);
        m_pol = '0;
        bus_rd(4'h4, d); check("R6 set beats clear", {31'd0, d[3]}, 32'd1);
        ctrl_wr(32'h0000_0008);
        bus_rd(4'h4, d); check("R5 later clear works", {31'd0, d[3]}, 32'd0);

        // R7: polarity flips with steady levels (pin 3 high, pin 4 low).
        ctrl_wr(32'h0000_1800);
        repeat (4) @(negedge clk);
        ctrl_wr(32'h0000_0000);
        repeat (4) @(negedge clk);
        bus_rd(4'h4, d); check("R7 polarity change no flag", d, {26'd0, m_flag});

        // R8: pull codes, reserved code keeps the old value.
        ctrl_wr(32'h0000_0002 << 16);
        check("R8 pull pin0 pull-down", {20'd0, pull_cfg}, {20'd0, exp_pull()});
        ctrl_wr((32'h0000_0003 << 16) | (32'h0000_0001 << 18));
        check("R8 reserved code ignored", {30'd0, pull_cfg[1:0]}, 32'd2);
        bus_rd(4'h0, d); check("R8 readback", d, exp_ctrl());

        // R9: writes to the flag register do nothing.
        pins_set(m_pin & ~6'b001000);
        pins_set(m_pin | 6'b001000);
        bus_wr(4'h4, 32'hFFFF_FFFF);
        bus_rd(4'h4, d); check("R9 flags read-only", d, {26'd0, m_flag});

        // R10: unmapped offsets, one-cycle strobe.
        bus_wr(4'hC, 32'hFFFF_FFFF);
        bus_rd(4'hC, d); check("R10 unmapped reads zero", d, 32'd0);
        check("R10 rvalid with data", {31'd0, bus_rvalid}, 32'd1);
        @(negedge clk);
        check("R10 rvalid one cycle", {31'd0, bus_rvalid}, 32'd0);
        check_all("R10 unmapped write ignored");

        // Random traffic against the model.
        for (int i = 0; i < 150; i++) begin
            logic [31:0] r;
            r = $urandom;
            case ($urandom % 4)
                0: pins_set(m_pin ^ r[5:0]);
                1: ctrl_wr(r);
                2: en_wr(r[5:0]);
                default: check_all("R4 random");
            endcase
            check("R4 random irq", {31'd0, irq}, {31'd0, |(m_flag & m_en)});
        end
        check_all("R3 random final");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule